// File: doc/BRIEF.md
# Prefix Even-Sum Detector

This combinational block takes an input vector `x` of `WIDTH` bits. For every bit position `j` it reports whether two running quantities are both even. The first is the number of ones among `x[0]` through `x[j]`. The second is the sum of those running counts over positions `0` through `j`.

The block never forms either sum. The evenness of the first count is the XOR of all bits up to `j`. The evenness of the second is the XOR of only those bits up to `j` whose index has the same parity as `j`. The input is split into an even-index lane and an odd-index lane. Each lane is reduced by its own prefix-XOR network. Each output bit then takes the two lane prefixes that reach up to its own position. It is high only when both of those prefixes are zero.

A parameter selects the prefix network shape: a log-depth dense tree, a log-depth sparse tree or a serial chain. All three give the same function.

Top module: `prefix_even_sum`

## Requirements
- R1: For every position j, y[j] is 1 exactly when both the count of ones in x[0..j] and the sum of those counts over positions 0..j are even integers.
- R2: y[0] equals the inverse of x[0]; with WIDTH of 1 this is the whole function.
- R3: An all-zero input drives every bit of y to 1.
- R4: y[j] depends only on x[0..j]; changing any bits above position j leaves y[0..j] unchanged.
- R5: Whenever the XOR of x[0..j] is 1, y[j] is 0.
- R6: Whenever the XOR of the bits x[k] with k not above j and k of the same index parity as j is 1, y[j] is 0.
- R7: The function holds for odd and even WIDTH values; a WIDTH below 1 or an unknown network selection stops elaboration.
- R8: The network selection (0 dense log-depth, 1 sparse log-depth, 2 serial chain) does not change y for any input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | Input bit vector, bit 0 is the first position |
| y | output | WIDTH | Per-position flag: both running sums even |

## Verification
Immediate assertions watch every change of `x`. They check each output bit against a direct masked-XOR model of both parities (R1, R5, R6). They also check the first-bit rule (R2) and the all-zero case (R3). Independence of lower outputs from upper inputs (R4) compares two different input vectors, so only the bench's scenarios can show it. The same holds for equality across network selections (R8) and for behaviour at several widths (R7). The bench covers these with exhaustive sweeps at 7 and 10 bits and with random vectors at 33 bits, all checked against integer sums.

// File: rtl/pes_pkg.sv
package pes_pkg;
   // Prefix network shapes
   localparam int PFX_DENSE  = 0;
   localparam int PFX_SPARSE = 1;
   localparam int PFX_CHAIN  = 2;

   // Number of positions in the even-index lane
   function automatic int even_lane_len(input int w);
      return (w + 1) / 2;
   endfunction

   // Number of positions in the odd-index lane
   function automatic int odd_lane_len(input int w);
      return w / 2;
   endfunction

   // Lane width never below one, so a vector can always be declared
   function automatic int safe_len(input int n);
      return (n < 1) ? 1 : n;
   endfunction

   // Levels of a log-depth prefix network over n elements
   function automatic int prefix_levels(input int n);
      return (n <= 1) ? 0 : $clog2(n);
   endfunction
endpackage

// File: rtl/pes_prefix_xor.sv
module pes_prefix_xor
   import pes_pkg::*;
#(
   parameter int N     = 8,
   parameter int SHAPE = PFX_DENSE
) (
   input  logic [N-1:0] d,
   output logic [N-1:0] p
);
   localparam int LEV = prefix_levels(N);

   if (N < 1) begin : g_bad_n
      $error("pes_prefix_xor: N must be at least 1");
   end
   if (SHAPE != PFX_DENSE && SHAPE != PFX_SPARSE && SHAPE != PFX_CHAIN) begin : g_bad_shape
      $error("pes_prefix_xor: unknown SHAPE");
   end

   if (SHAPE == PFX_CHAIN) begin : g_chain
      logic [N-1:0] run;
      assign run[0] = d[0];
      for (genvar i = 1; i < N; i++) begin : g_link
         assign run[i] = run[i-1] ^ d[i];
      end
      assign p = run;
   end else if (SHAPE == PFX_SPARSE) begin : g_sparse
      logic [N-1:0] stg [0:LEV];
      assign stg[0] = d;
      for (genvar l = 0; l < LEV; l++) begin : g_lvl
         for (genvar i = 0; i < N; i++) begin : g_pos
            localparam int SRC = ((i >> l) << l) - 1;
            if (((i >> l) & 1) == 1) begin : g_mix
               assign stg[l+1][i] = stg[l][i] ^ stg[l][SRC];
            end else begin : g_pass
               assign stg[l+1][i] = stg[l][i];
            end
         end
      end
      assign p = stg[LEV];
   end else begin : g_dense
      logic [N-1:0] stg [0:LEV];
      assign stg[0] = d;
      for (genvar l = 0; l < LEV; l++) begin : g_lvl
         localparam int DIST = 1 << l;
         for (genvar i = 0; i < N; i++) begin : g_pos
            if (i >= DIST) begin : g_mix
               assign stg[l+1][i] = stg[l][i] ^ stg[l][i-DIST];
            end else begin : g_pass
               assign stg[l+1][i] = stg[l][i];
            end
         end
      end
      assign p = stg[LEV];
   end
endmodule

// File: rtl/pes_lane_split.sv
module pes_lane_split
   import pes_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]                              x,
   output logic [safe_len(even_lane_len(WIDTH))-1:0]     ev,
   output logic [safe_len(odd_lane_len(WIDTH))-1:0]      od
);
   localparam int NE = even_lane_len(WIDTH);
   localparam int NO = odd_lane_len(WIDTH);

   for (genvar k = 0; k < NE; k++) begin : g_even
      assign ev[k] = x[2*k];
   end

   if (NO > 0) begin : g_odd
      for (genvar k = 0; k < NO; k++) begin : g_bit
         assign od[k] = x[2*k+1];
      end
   end else begin : g_odd_none
      assign od = 1'b0;
   end
endmodule

// File: rtl/pes_combine.sv
module pes_combine
   import pes_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [safe_len(even_lane_len(WIDTH))-1:0] ev_pfx,
   input  logic [safe_len(odd_lane_len(WIDTH))-1:0]  od_pfx,
   output logic [WIDTH-1:0]                          y
);
   for (genvar j = 0; j < WIDTH; j++) begin : g_pos
      localparam int K = j / 2;
      logic all_par;
      logic same_par;
      if ((j % 2) == 0) begin : g_even_pos
         // odd indices up to j end at lane slot K-1
         if (K > 0) begin : g_with_odd
            assign all_par = ev_pfx[K] ^ od_pfx[K-1];
         end else begin : g_first
            assign all_par = ev_pfx[K];
         end
         assign same_par = ev_pfx[K];
      end else begin : g_odd_pos
         assign all_par  = ev_pfx[K] ^ od_pfx[K];
         assign same_par = od_pfx[K];
      end
      assign y[j] = ~all_par & ~same_par;
   end
endmodule

// File: rtl/prefix_even_sum.sv
module prefix_even_sum
   import pes_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int SHAPE = PFX_DENSE
) (
   input  logic [WIDTH-1:0] x,
   output logic [WIDTH-1:0] y
);
   localparam int NE  = even_lane_len(WIDTH);
   localparam int NO  = odd_lane_len(WIDTH);
   localparam int NES = safe_len(NE);
   localparam int NOS = safe_len(NO);

   if (WIDTH < 1) begin : g_bad_width
      $error("prefix_even_sum: WIDTH must be at least 1");
   end
   if (SHAPE != PFX_DENSE && SHAPE != PFX_SPARSE && SHAPE != PFX_CHAIN) begin : g_bad_shape
      $error("prefix_even_sum: SHAPE must be 0, 1 or 2");
   end

   logic [NES-1:0] ev_bits, ev_pfx;
   logic [NOS-1:0] od_bits, od_pfx;

   pes_lane_split #(.WIDTH(WIDTH)) u_split (
      .x  (x),
      .ev (ev_bits),
      .od (od_bits)
   );

   pes_prefix_xor #(.N(NES), .SHAPE(SHAPE)) u_even_net (
      .d (ev_bits),
      .p (ev_pfx)
   );

   if (NO > 0) begin : g_odd_net
      pes_prefix_xor #(.N(NOS), .SHAPE(SHAPE)) u_odd_net (
         .d (od_bits),
         .p (od_pfx)
      );
   end else begin : g_no_odd
      assign od_pfx = od_bits;
   end

   pes_combine #(.WIDTH(WIDTH)) u_comb (
      .ev_pfx (ev_pfx),
      .od_pfx (od_pfx),
      .y      (y)
   );
endmodule

// File: rtl/prefix_even_sum_chk.sv
module prefix_even_sum_chk #(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0] x,
   input logic [WIDTH-1:0] y
);
   always_comb begin
      if (!$isunknown(x)) begin
         AST_FIRST_BIT: assert (y[0] == ~x[0]);                                  // R2
         if (x == '0) begin
            AST_ZERO_ALL_ONES: assert (&y);                                      // R3
         end
         for (int j = 0; j < WIDTH; j++) begin
            logic all_p;
            logic same_p;
            all_p  = 1'b0;
            same_p = 1'b0;
            for (int k = 0; k <= j; k++) begin
               all_p = all_p ^ x[k];
               if ((k % 2) == (j % 2)) same_p = same_p ^ x[k];
            end
            if (all_p) begin
               AST_ODD_COUNT_LOW: assert (!y[j]);                                // R5
            end
            if (same_p) begin
               AST_ODD_SUM_LOW: assert (!y[j]);                                  // R6
            end
            AST_REF_MATCH: assert (y[j] == (!all_p && !same_p));                 // R1
         end
      end
   end
endmodule

bind prefix_even_sum prefix_even_sum_chk #(.WIDTH(WIDTH)) u_chk (.x(x), .y(y));

// File: tb/prefix_even_sum_test.sv
`timescale 1ns/1ps
module prefix_even_sum_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [9:0]  xa;  logic [9:0] ya, yb, yc;
   logic [0:0]  x1;  logic [0:0] y1;
   logic [6:0]  x7;  logic [6:0] y7;
   logic [32:0] xw;  logic [32:0] yw;

   prefix_even_sum #(.WIDTH(10), .SHAPE(0)) uut     (.x(xa), .y(ya));
   prefix_even_sum #(.WIDTH(10), .SHAPE(1)) uut_spr (.x(xa), .y(yb));
   prefix_even_sum #(.WIDTH(10), .SHAPE(2)) uut_chn (.x(xa), .y(yc));
   prefix_even_sum #(.WIDTH(1))             uut_w1  (.x(x1), .y(y1));
   prefix_even_sum #(.WIDTH(7), .SHAPE(1))  uut_w7  (.x(x7), .y(y7));
   prefix_even_sum #(.WIDTH(33))            uut_w33 (.x(xw), .y(yw));

   // Integer model: running count and running sum of counts
   function automatic logic [63:0] model(input logic [63:0] v, input int w);
      logic [63:0] r;
      int s;
      int t;
      r = '0; s = 0; t = 0;
      for (int j = 0; j < w; j++) begin
         s = s + int'(v[j]);
         t = t + s;
         r[j] = ((s % 2) == 0) && ((t % 2) == 0);
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #5;
   endtask

   initial begin
      xa = '0; x1 = '0; x7 = '0; xw = '0;
      void'($urandom(32'd7741));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      step();
      // R3: all-zero input gives all ones at every width
      check("R3 w10", 64'(ya), 64'h3FF);
      check("R3 w1",  64'(y1), 64'h1);
      check("R3 w7",  64'(y7), 64'h7F);
      check("R3 w33", 64'(yw), 64'h1_FFFF_FFFF);

      // R2: single-bit width
      x1 = 1'b1; step();
      check("R2 w1 x=1", 64'(y1), 64'h0);
      x1 = 1'b0; step();
      check("R2 w1 x=0", 64'(y1), 64'h1);

      // R5: lone one at bit 3 clears y from 3 upward
      xa = 10'h008; step();
      check("R5 lone one", 64'(ya), 64'h007);
      // R6: bits 1 and 2 set: counts even at 2 and 3, sums odd there
      xa = 10'h006; step();
      check("R6 same-parity sum", 64'(ya[3:2]), 64'h0);
      check("R6 full", 64'(ya), model(64'(xa), 10));

      // R1, R8: exhaustive at 10 bits, all three shapes
      for (int v = 0; v < 1024; v++) begin
         xa = v[9:0]; step();
         check("R1 w10 dense", 64'(ya), model(64'(xa), 10));
         check("R8 sparse", 64'(yb), 64'(ya));
         check("R8 chain",  64'(yc), 64'(ya));
      end

      // R7: odd width exhaustive
      for (int v = 0; v < 128; v++) begin
         x7 = v[6:0]; step();
         check("R7 w7", 64'(y7), model(64'(x7), 7));
      end

      // R1 random at 33 bits, R4 upper bits have no effect on lower outputs
      for (int n = 0; n < 300; n++) begin
         logic [32:0] low_out;
         logic [32:0] keep;
         int j;
         xw = {$urandom, $urandom} & 33'h1_FFFF_FFFF;
         if (n % 10 == 0) xw = {33{n[4]}} ^ 33'h1_5555_5555;
         step();
         check("R1 w33", 64'(yw), model(64'(xw), 33));
         j = int'($urandom % 33);
         keep = (33'h1 << (j + 1)) - 33'h1;
         if (j == 32) keep = '1;
         low_out = yw & keep;
         xw = (xw & keep) | ({$urandom, $urandom} & ~keep);
         step();
         check("R4 causal", 64'(yw & keep), 64'(low_out));
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule